// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block decides which of eight interrupt levels, if any, should be offered to a processor right now. It looks at three vectors: the levels currently asking for service, a mask that blocks some of them, and the levels already being serviced. Priorities are not fixed to level numbers. A rotation offset names the level that ranks highest, and the ranking then wraps upward through the remaining levels. The block finds the best unmasked request and the best in-service level under that ranking. It offers the request only if it strictly beats everything already in service.

A master unit in a cascaded pair can run a nesting mode in which its cascade input, level 2, does not count as in service. This lets further requests from the downstream unit reach the processor while one of its requests is already being handled. The resolver is purely combinational. It sits between the register bank of an interrupt controller and its request output, and its result follows its inputs in the same cycle. It carries no data stream, so it has no valid/ready handshake. All of its pins are plain control inputs and status outputs.

Top module: `rot_nest_resolver`

## Requirements
- R1: The relative priority of level L under offset O is (L - O) mod 8, and 0 is the best. Among the candidates, the one with the smallest relative priority is selected.
- R2: When no level is both requested and unmasked, `grant_valid` is 0. This includes the all-zero input state.
- R3: A level whose `mask_vec` bit is 1 is never selected, even if it is the best-ranked request.
- R4: When `insvc_vec` is empty, which ranks as priority 8, the best candidate is always presented.
- R5: A candidate whose relative priority is equal to or worse than that of the best in-service level is not presented (`grant_valid` = 0).
- R6: A candidate whose relative priority is strictly better than that of the best in-service level is presented.
- R7: When `nest_en` = 1 and `is_master` = 1, bit 2 of `insvc_vec` is ignored in the in-service ranking.
- R8: When either `nest_en` or `is_master` is 0, bit 2 of `insvc_vec` takes part in the in-service ranking like any other bit.
- R9: `grant_level` equals (winning relative priority + offset) mod 8 when `grant_valid` = 1, and it is 0 when `grant_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_vec | input | 8 | Pending request per level |
| mask_vec | input | 8 | 1 blocks the corresponding request |
| insvc_vec | input | 8 | Levels currently in service |
| rot_ofs | input | 3 | Level that holds relative priority 0 |
| nest_en | input | 1 | Nesting mode enable |
| is_master | input | 1 | Unit is the master of a cascade |
| grant_valid | output | 1 | A request should be offered |
| grant_level | output | 3 | Level being offered |

## Verification
A wrong rotation shows up at once as a different `grant_level` whenever two or more candidates are present. A faulty in-service comparison shows up as `grant_valid` rising or staying low in the very cycle the vectors are applied, and the equal-rank boundary case exposes it most directly. Since the block holds no state, every error is visible in the same cycle as its stimulus. For that reason the bench sweeps all eight offsets under both settings of the nesting controls and compares each cycle against a loop model written from the requirements.

// File: rtl/rot_pri_pkg.sv
package rot_pri_pkg;

  // Addition modulo n for small non-negative operands.
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    while (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/rot_prio_enc.sv
// Finds the relative priority of the best set bit of vec_i, where ofs_i is
// the level that ranks first. An empty vector yields N.
module rot_prio_enc
  import rot_pri_pkg::*;
#(
  parameter int N  = 8,
  localparam int OW = $clog2(N),
  localparam int PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [OW-1:0] ofs_i,
  output logic [PW-1:0] prio_o
);

  logic [N-1:0] rot_vec;

  // Rotate so that bit p of rot_vec holds the level of relative priority p.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rot
      always_comb begin
        rot_vec[g] = vec_i[wrap_add(g, int'(ofs_i), N)];
      end
    end
  endgenerate

  // Fixed encoder: the lowest set bit of the rotated vector wins.
  always_comb begin
    prio_o = PW'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot_vec[p]) prio_o = PW'(p);
    end
  end

  // A reported priority must point back at a set bit of the input.
  always_comb begin
    if (prio_o != PW'(N)) begin
      AST_PRIO_HITS_SET_BIT: assert (vec_i[wrap_add(int'(prio_o), int'(ofs_i), N)])
        else $error("encoder priority points at a clear bit"); // R1
    end
  end

endmodule

// File: rtl/svc_filter.sv
// Builds the in-service vector used for ranking; in nesting mode a master
// drops its cascade level.
module svc_filter #(
  parameter int N    = 8,
  parameter int CASC = 2
) (
  input  logic [N-1:0] insvc_i,
  input  logic         nest_en_i,
  input  logic         master_i,
  output logic [N-1:0] eff_svc_o
);

  logic drop_casc;

  always_comb begin
    drop_casc = nest_en_i & master_i;
    eff_svc_o = insvc_i;
    if (drop_casc) eff_svc_o[CASC] = 1'b0;
  end

  always_comb begin
    AST_SVC_SUBSET: assert ((eff_svc_o & ~insvc_i) == '0)
      else $error("filtered in-service has extra bits"); // R8
  end

endmodule

// File: rtl/rot_nest_resolver.sv
module rot_nest_resolver
  import rot_pri_pkg::*;
#(
  parameter int N    = 8,
  parameter int CASC = 2,
  localparam int OW  = $clog2(N),
  localparam int PW  = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_vec,
  input  logic [N-1:0]  mask_vec,
  input  logic [N-1:0]  insvc_vec,
  input  logic [OW-1:0] rot_ofs,
  input  logic          nest_en,
  input  logic          is_master,
  output logic          grant_valid,
  output logic [OW-1:0] grant_level
);

  logic [N-1:0]  cand_vec;
  logic [N-1:0]  eff_svc;
  logic [PW-1:0] cand_pri;
  logic [PW-1:0] svc_pri;

  always_comb cand_vec = req_vec & ~mask_vec;

  svc_filter #(.N(N), .CASC(CASC)) u_svc_filter (
    .insvc_i   (insvc_vec),
    .nest_en_i (nest_en),
    .master_i  (is_master),
    .eff_svc_o (eff_svc)
  );

  rot_prio_enc #(.N(N)) u_cand_enc (
    .vec_i  (cand_vec),
    .ofs_i  (rot_ofs),
    .prio_o (cand_pri)
  );

  rot_prio_enc #(.N(N)) u_svc_enc (
    .vec_i  (eff_svc),
    .ofs_i  (rot_ofs),
    .prio_o (svc_pri)
  );

  // An empty candidate set ranks N, which can never beat any in-service rank.
  always_comb begin
    grant_valid = (cand_pri != PW'(N)) && (cand_pri < svc_pri);
    grant_level = '0;
    if (grant_valid) grant_level = OW'(wrap_add(int'(cand_pri), int'(rot_ofs), N));
  end

  always_comb begin
    if (grant_valid) begin
      AST_GRANT_HAS_CAND: assert (cand_vec != '0)
        else $error("grant with no candidate"); // R2
      AST_GRANT_UNMASKED: assert (req_vec[grant_level] && !mask_vec[grant_level])
        else $error("granted level is masked or idle"); // R3
      AST_GRANT_NOT_IN_SVC: assert (!eff_svc[grant_level])
        else $error("granted level already in service"); // R5
    end else begin
      AST_IDLE_LEVEL_ZERO: assert (grant_level == '0)
        else $error("level nonzero while idle"); // R9
    end
  end

endmodule

// File: tb/tb_rot_nest_resolver.sv
module tb_rot_nest_resolver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_vec = '0;
  logic [7:0] mask_vec = '0;
  logic [7:0] insvc_vec = '0;
  logic [2:0] rot_ofs = '0;
  logic       nest_en = 1'b0;
  logic       is_master = 1'b0;
  logic       grant_valid;
  logic [2:0] grant_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit       v;
    bit [2:0] l;
    string    tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  rot_nest_resolver dut (
    .req_vec     (req_vec),
    .mask_vec    (mask_vec),
    .insvc_vec   (insvc_vec),
    .rot_ofs     (rot_ofs),
    .nest_en     (nest_en),
    .is_master   (is_master),
    .grant_valid (grant_valid),
    .grant_level (grant_level)
  );

  function automatic int rel_rank(input bit [7:0] v, input int off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  task automatic drive(input bit [7:0] r, input bit [7:0] m, input bit [7:0] s,
                       input bit [2:0] o, input bit sf, input bit ms,
                       input bit ev, input bit [2:0] el, input string tag);
    @(posedge clk);
    #1;
    req_vec = r; mask_vec = m; insvc_vec = s;
    rot_ofs = o; nest_en = sf; is_master = ms;
    expq.push_back('{ev, el, tag});
  endtask

  task automatic drive_model(input bit [7:0] r, input bit [7:0] m, input bit [7:0] s,
                             input bit [2:0] o, input bit sf, input bit ms, input string tag);
    bit [7:0] es;
    int pc, ps;
    bit ev;
    bit [2:0] el;
    es = s;
    if (sf && ms) es[2] = 1'b0;
    pc = rel_rank(r & ~m, o);
    ps = rel_rank(es, o);
    ev = (pc < 8) && (pc < ps);
    el = ev ? 3'((pc + o) % 8) : 3'd0;
    drive(r, m, s, o, sf, ms, ev, el, tag);
  endtask

  // Monitor: compares away from the driving edge.
  always @(negedge clk) begin
    if (rst_n && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (grant_valid !== e.v || grant_level !== e.l) begin
        errors++;
        $display("FAIL %s: got valid=%0b level=%0d, expected valid=%0b level=%0d",
                 e.tag, grant_valid, grant_level, e.v, e.l);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    lfsr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all inputs zero
    drive(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0, 3'd0, "R2 reset idle");
    drive(8'hFF, 8'hFF, 8'h00, 3'd0, 0, 0, 0, 3'd0, "R2 all masked");
    drive(8'h11, 8'h00, 8'h00, 3'd5, 0, 0, 1, 3'd0, "R1 rotated winner");
    drive(8'h11, 8'h00, 8'h00, 3'd1, 0, 0, 1, 3'd4, "R1 rotated winner 2");
    drive(8'h03, 8'h01, 8'h00, 3'd0, 0, 0, 1, 3'd1, "R3 masked best");
    drive(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, 1, 3'd7, "R4 empty service");
    drive(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0, 3'd0, "R5 equal rank");
    drive(8'h10, 8'h00, 8'h08, 3'd0, 0, 0, 0, 3'd0, "R5 lower rank");
    drive(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 1, 3'd2, "R6 higher rank");
    drive(8'h08, 8'h00, 8'h10, 3'd4, 0, 0, 0, 3'd0, "R6 rotated lower");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 1, 1, 1, 3'd2, "R7 cascade nested");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1, 1, 1, 3'd3, "R7 cascade ignored");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1, 0, 0, 3'd0, "R8 not master");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 0, 3'd0, "R8 nesting off");
    drive(8'h40, 8'h00, 8'h00, 3'd7, 0, 0, 1, 3'd6, "R9 wrap level");
    drive(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, 1, 3'd7, "R9 offset level");
    // Sweep: all offsets, all nesting settings, pseudo-random vectors
    for (int o = 0; o < 8; o++) begin
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < 150; k++) begin
          bit [7:0] r, m, s;
          lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
          r = lfsr[7:0];
          m = lfsr[15:8] & lfsr[23:16];
          s = lfsr[31:24] & {lfsr[3:0], lfsr[7:4]};
          drive_model(r, m, s, 3'(o), c[0], c[1], "R1 R5 R6 R7 R8 R9 sweep");
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule